// File: doc/BRIEF.md
# Wake-Up Filter Table Access Port

This block holds the configuration table for a bank-organised set of wake-up packet filters and gives software sequential access to it through one data port. Software first clears an internal word pointer. It then writes every word of the table in turn, and the pointer steps forward by one after each accepted access. Reads use the same port and the same pointer order. The current pointer value is always visible as a status output.

The table is kept in two copies. The first copy is a shadow in the CPU clock domain, and reads are served from it. The second copy lives in the receive clock domain and drives the filter configuration outputs. Each accepted write is handed across the clock boundary by a toggle request and a toggle acknowledge. While the write is in flight a busy flag stays high, and any further write that arrives in that time is dropped. The receive-side copy is unpacked into per-filter byte masks, commands, offsets and CRC-16 values for the matching logic downstream.

Top module: `wkf_regfile`

## Requirements
- R1: The table holds 8×NUM_BANKS words of 32 bits, with NUM_BANKS restricted to 1, 2 or 4. The pointer is $clog2(8×NUM_BANKS) bits wide.
- R2: A write strobe that is accepted (busy low, no pointer clear) stores the data at the word the pointer addresses and advances the pointer by one. The pointer wraps from the last word to 0.
- R3: A read strobe with no write and no clear in the same cycle loads the addressed word into the registered read data one clock later and advances the pointer by one. The read data holds its value in every other cycle.
- R4: A pointer clear sets the pointer to 0 on the next clock. Any write or read strobe in the same cycle is dropped.
- R5: Busy rises in the cycle after an accepted write. It stays high until the receive-domain acknowledge returns, which takes at least 3 CPU cycles.
- R6: A write strobe that arrives while busy is high stores nothing, does not move the pointer and does not reach the receive copy.
- R7: The receive-side copy, and so the configuration outputs, changes only after the request has passed the receive-domain synchronizer. The new word is present on the outputs by the time busy falls.
- R8: Within bank b, words 8b+0 to 8b+3 are the 32-bit byte masks of filters 4b+0 to 4b+3.
- R9: Word 8b+4 carries the 4-bit commands of the bank's four filters, and word 8b+5 carries their 8-bit offsets. In both words, filter f of the bank uses byte lane f (bits 8f upward). Each command sits in the low nibble of its lane.
- R10: Word 8b+6 holds the CRC-16 of filters 4b+0 (bits 15:0) and 4b+1 (bits 31:16). Word 8b+7 holds those of filters 4b+2 and 4b+3 in the same way.
- R11: After reset the pointer, busy, read data and all configuration outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | CPU-side active-low reset |
| acc_wr | input | 1 | Write strobe for the data port |
| acc_rd | input | 1 | Read strobe for the data port |
| ptr_clr | input | 1 | Return the word pointer to 0 |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| ptr_val | output | $clog2(8*NUM_BANKS) | Current word pointer |
| busy | output | 1 | A write is crossing into the receive domain |
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive-side active-low reset |
| flt_mask | output | 32*4*NUM_BANKS | Byte mask per filter, filter i at bits 32i |
| flt_cmd | output | 4*4*NUM_BANKS | Command per filter, filter i at bits 4i |
| flt_offset | output | 8*4*NUM_BANKS | Offset per filter, filter i at bits 8i |
| flt_crc | output | 16*4*NUM_BANKS | CRC-16 per filter, filter i at bits 16i |

## Verification
The pointer, busy and read data are due on the first CPU edge after a strobe. The bench drives each strobe on a falling edge and samples one falling edge later, so each check lands half a cycle after the register has updated. The receive copy has no fixed latency in CPU cycles. The bench therefore checks the outputs at the first falling edge after a write, where they must still hold the old value, and again once busy has fallen, where they must hold the new one. It also counts the busy cycles against a lower and an upper bound.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
   localparam int WORD_W         = 32;
   localparam int WORDS_PER_BANK = 8;
   localparam int FILT_PER_BANK  = 4;
   localparam int CMD_W          = 4;
   localparam int OFS_W          = 8;
   localparam int CRC_W          = 16;
   localparam int LANE_W         = 8;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wkf_cpu_port.sv
module wkf_cpu_port
   import wkf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int PTR_W     = $clog2(NUM_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic             clr,
   input  word_t            wdata,
   input  logic             ack_sync,
   output word_t            rdata,
   output logic [PTR_W-1:0] ptr,
   output logic             busy,
   output logic             req_tgl,
   output logic [PTR_W-1:0] hold_addr,
   output word_t            hold_data
);
   word_t shadow [NUM_WORDS];
   logic  wr_ok, rd_ok;

   assign busy  = req_tgl ^ ack_sync;
   assign wr_ok = wr & ~busy & ~clr;
   assign rd_ok = rd & ~wr & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         rdata     <= '0;
         req_tgl   <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (wr_ok) begin
         hold_addr <= ptr;
         hold_data <= wdata;
         req_tgl   <= ~req_tgl;
         ptr       <= ptr + PTR_W'(1);
      end else if (rd_ok) begin
         rdata <= shadow[ptr];
         ptr   <= ptr + PTR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) shadow[i] <= '0;
      end else if (wr_ok) begin
         shadow[ptr] <= wdata;
      end
   end
endmodule

// File: rtl/wkf_rx_store.sv
module wkf_rx_store
   import wkf_pkg::*;
#(
   parameter int NUM_WORDS   = 16,
   parameter int PTR_W       = $clog2(NUM_WORDS),
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_tgl,
   input  logic [PTR_W-1:0]            hold_addr,
   input  word_t                       hold_data,
   output logic                        ack_tgl,
   output logic [NUM_WORDS*WORD_W-1:0] words
);
   word_t mem [NUM_WORDS];
   logic  req_s, req_seen, upd;

   wkf_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   assign upd     = req_s ^ req_seen;
   assign ack_tgl = req_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_seen <= 1'b0;
      else if (upd) req_seen <= req_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      end else if (upd) begin
         mem[hold_addr] <= hold_data;
      end
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flat
      assign words[w*WORD_W +: WORD_W] = mem[w];
   end
endmodule

// File: rtl/wkf_field_map.sv
module wkf_field_map
   import wkf_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   localparam int NUM_WORDS = NUM_BANKS * WORDS_PER_BANK,
   localparam int NUM_FILT  = NUM_BANKS * FILT_PER_BANK
) (
   input  logic [NUM_WORDS*WORD_W-1:0] words,
   output logic [NUM_FILT*WORD_W-1:0]  mask,
   output logic [NUM_FILT*CMD_W-1:0]   cmd,
   output logic [NUM_FILT*OFS_W-1:0]   offset,
   output logic [NUM_FILT*CRC_W-1:0]   crc
);
   localparam int CMD_WORD = 4;
   localparam int OFS_WORD = 5;
   localparam int CRC_WORD = 6;
   localparam int CRC_PER_WORD = WORD_W / CRC_W;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int BASE = b * WORDS_PER_BANK;
      word_t cmd_word, ofs_word;
      logic [FILT_PER_BANK*(LANE_W-CMD_W)-1:0] cmd_spare_unused;

      assign cmd_word = words[(BASE+CMD_WORD)*WORD_W +: WORD_W];
      assign ofs_word = words[(BASE+OFS_WORD)*WORD_W +: WORD_W];

      for (genvar f = 0; f < FILT_PER_BANK; f++) begin : g_filt
         localparam int FI = b * FILT_PER_BANK + f;
         localparam int CW = BASE + CRC_WORD + f / CRC_PER_WORD;
         localparam int CS = (f % CRC_PER_WORD) * CRC_W;
         assign mask[FI*WORD_W +: WORD_W] = words[(BASE+f)*WORD_W +: WORD_W];
         assign cmd[FI*CMD_W +: CMD_W]    = cmd_word[f*LANE_W +: CMD_W];
         assign offset[FI*OFS_W +: OFS_W] = ofs_word[f*LANE_W +: OFS_W];
         assign crc[FI*CRC_W +: CRC_W]    = words[CW*WORD_W + CS +: CRC_W];
         assign cmd_spare_unused[f*(LANE_W-CMD_W) +: (LANE_W-CMD_W)] =
            cmd_word[f*LANE_W+CMD_W +: (LANE_W-CMD_W)];
      end
   end
endmodule

// File: rtl/wkf_regfile.sv
module wkf_regfile
   import wkf_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                          cpu_clk,
   input  logic                                          cpu_rst_n,
   input  logic                                          acc_wr,
   input  logic                                          acc_rd,
   input  logic                                          ptr_clr,
   input  logic [WORD_W-1:0]                             acc_wdata,
   output logic [WORD_W-1:0]                             acc_rdata,
   output logic [$clog2(WORDS_PER_BANK*NUM_BANKS)-1:0]   ptr_val,
   output logic                                          busy,
   input  logic                                          rx_clk,
   input  logic                                          rx_rst_n,
   output logic [FILT_PER_BANK*NUM_BANKS*WORD_W-1:0]     flt_mask,
   output logic [FILT_PER_BANK*NUM_BANKS*CMD_W-1:0]      flt_cmd,
   output logic [FILT_PER_BANK*NUM_BANKS*OFS_W-1:0]      flt_offset,
   output logic [FILT_PER_BANK*NUM_BANKS*CRC_W-1:0]      flt_crc
);
   localparam int NUM_WORDS = WORDS_PER_BANK * NUM_BANKS;
   localparam int PTR_W     = $clog2(NUM_WORDS);

   initial begin
      assert (NUM_BANKS == 1 || NUM_BANKS == 2 || NUM_BANKS == 4)
         else $error("wkf_regfile: NUM_BANKS must be 1, 2 or 4");
      assert (SYNC_STAGES >= 2)
         else $error("wkf_regfile: SYNC_STAGES must be at least 2");
   end

   logic                        req_tgl, ack_tgl, ack_sync;
   logic [PTR_W-1:0]            hold_addr;
   word_t                       hold_data;
   logic [NUM_WORDS*WORD_W-1:0] rx_words;

   wkf_cpu_port #(.NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)) u_cpu (
      .clk(cpu_clk), .rst_n(cpu_rst_n),
      .wr(acc_wr), .rd(acc_rd), .clr(ptr_clr), .wdata(acc_wdata),
      .ack_sync(ack_sync),
      .rdata(acc_rdata), .ptr(ptr_val), .busy(busy),
      .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data)
   );

   wkf_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_sync)
   );

   wkf_rx_store #(.NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W),
                  .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(rx_clk), .rst_n(rx_rst_n),
      .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
      .ack_tgl(ack_tgl), .words(rx_words)
   );

   wkf_field_map #(.NUM_BANKS(NUM_BANKS)) u_map (
      .words(rx_words),
      .mask(flt_mask), .cmd(flt_cmd), .offset(flt_offset), .crc(flt_crc)
   );
endmodule

// File: rtl/wkf_regfile_chk.sv
module wkf_regfile_chk #(
   parameter int PTR_W = 5
) (
   input logic             cpu_clk,
   input logic             cpu_rst_n,
   input logic             acc_wr,
   input logic             acc_rd,
   input logic             ptr_clr,
   input logic             busy,
   input logic [PTR_W-1:0] ptr_val,
   input logic [31:0]      acc_rdata
);
   p_busy_set_r5: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (acc_wr && !busy && !ptr_clr) |=> busy);

   p_wr_adv_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (acc_wr && !busy && !ptr_clr) |=> ptr_val == PTR_W'($past(ptr_val) + 1'b1));

   p_wr_drop_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (acc_wr && busy && !ptr_clr) |=> $stable(ptr_val));

   p_clr_zero_r4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      ptr_clr |=> ptr_val == '0);

   p_rd_adv_r3: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (acc_rd && !acc_wr && !ptr_clr) |=> ptr_val == PTR_W'($past(ptr_val) + 1'b1));

   p_rdata_hold_r3: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      !(acc_rd && !acc_wr && !ptr_clr) |=> $stable(acc_rdata));
endmodule

bind wkf_regfile wkf_regfile_chk #(.PTR_W($clog2(8 * NUM_BANKS))) u_chk (
   .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
   .acc_wr(acc_wr), .acc_rd(acc_rd), .ptr_clr(ptr_clr),
   .busy(busy), .ptr_val(ptr_val), .acc_rdata(acc_rdata)
);

// File: tb/wkf_regfile_bench.sv
module wkf_regfile_bench;
   localparam int NB = 2;
   localparam int NW = 8 * NB;
   localparam int NF = 4 * NB;
   localparam int PW = $clog2(NW);

   logic cpu_clk = 0, rx_clk = 0, cpu_rst_n = 0, rx_rst_n = 0;
   logic acc_wr = 0, acc_rd = 0, ptr_clr = 0;
   logic [31:0] acc_wdata = 0, acc_rdata;
   logic [PW-1:0] ptr_val;
   logic busy;
   logic [NF*32-1:0] flt_mask;
   logic [NF*4-1:0]  flt_cmd;
   logic [NF*8-1:0]  flt_offset;
   logic [NF*16-1:0] flt_crc;

   always #10 cpu_clk = ~cpu_clk;
   always #14 rx_clk  = ~rx_clk;

   wkf_regfile #(.NUM_BANKS(NB)) u_wkf_regfile (
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .ptr_clr(ptr_clr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .ptr_val(ptr_val), .busy(busy), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
      .flt_mask(flt_mask), .flt_cmd(flt_cmd), .flt_offset(flt_offset), .flt_crc(flt_crc)
   );

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] exp_mem [NW];
   int exp_ptr = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(int k, int p);
      return (32'(k + 1) * 32'h0103_0507) ^ (p[0] ? 32'hA5C3_0F96 : 32'h0);
   endfunction

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 200) begin @(negedge cpu_clk); n++; end
   endtask

   // accepted write: checks R2 pointer step and R5 busy timing
   task automatic do_write(input logic [31:0] d);
      int n;
      @(negedge cpu_clk); acc_wr = 1; acc_wdata = d;
      @(negedge cpu_clk); acc_wr = 0;
      exp_mem[exp_ptr] = d;
      exp_ptr = (exp_ptr + 1) % NW;
      chk(busy === 1'b1, "R5", "busy after write", 32'(busy), 1);
      chk(ptr_val === PW'(exp_ptr), "R2", "pointer after write", 32'(ptr_val), 32'(exp_ptr));
      wait_idle(n);
      chk(n >= 3 && n <= 20, "R5", "busy length", n, 3);
   endtask

   task automatic do_read();
      logic [31:0] e;
      e = exp_mem[exp_ptr];
      @(negedge cpu_clk); acc_rd = 1;
      @(negedge cpu_clk); acc_rd = 0;
      exp_ptr = (exp_ptr + 1) % NW;
      chk(acc_rdata === e, "R3", "read data", acc_rdata, e);
      chk(ptr_val === PW'(exp_ptr), "R3", "pointer after read", 32'(ptr_val), 32'(exp_ptr));
   endtask

   task automatic do_clr();
      @(negedge cpu_clk); ptr_clr = 1;
      @(negedge cpu_clk); ptr_clr = 0;
      exp_ptr = 0;
      chk(ptr_val === '0, "R4", "pointer after clear", 32'(ptr_val), 0);
   endtask

   task automatic chk_fields();
      for (int i = 0; i < NF; i++) begin
         int b = i / 4, f = i % 4;
         logic [31:0] cw, ow, crw;
         cw  = exp_mem[b*8+4];
         ow  = exp_mem[b*8+5];
         crw = exp_mem[b*8+6+f/2];
         chk(flt_mask[i*32 +: 32] === exp_mem[b*8+f], "R8", "mask",
             flt_mask[i*32 +: 32], exp_mem[b*8+f]);
         chk(flt_cmd[i*4 +: 4] === cw[f*8 +: 4], "R9", "command",
             32'(flt_cmd[i*4 +: 4]), 32'(cw[f*8 +: 4]));
         chk(flt_offset[i*8 +: 8] === ow[f*8 +: 8], "R9", "offset",
             32'(flt_offset[i*8 +: 8]), 32'(ow[f*8 +: 8]));
         chk(flt_crc[i*16 +: 16] === crw[(f%2)*16 +: 16], "R10", "crc",
             32'(flt_crc[i*16 +: 16]), 32'(crw[(f%2)*16 +: 16]));
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge cpu_clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      int n;
      logic [31:0] a, bval, c, old_rd;
      for (int k = 0; k < NW; k++) exp_mem[k] = '0;
      repeat (3) @(negedge cpu_clk);
      cpu_rst_n = 1; rx_rst_n = 1;
      @(negedge cpu_clk);
      // R11 reset state
      chk(ptr_val === '0, "R11", "reset pointer", 32'(ptr_val), 0);
      chk(busy === 1'b0, "R11", "reset busy", 32'(busy), 0);
      chk(acc_rdata === '0, "R11", "reset rdata", acc_rdata, 0);
      chk(flt_mask === '0 && flt_cmd === '0 && flt_offset === '0 && flt_crc === '0,
          "R11", "reset outputs", 32'(flt_mask[31:0]), 0);

      // R1/R2: full table pass, pointer wraps after word NW-1
      do_clr();
      for (int k = 0; k < NW; k++) do_write(pat(k, 0));
      chk(ptr_val === '0, "R1", "pointer wrap after full table", 32'(ptr_val), 0);
      chk_fields();
      // R3: sequential read-back
      for (int k = 0; k < NW; k++) do_read();

      // R6: write while busy is dropped
      do_clr();
      a = 32'hDEAD_0001; bval = 32'hBEEF_0002;
      @(negedge cpu_clk); acc_wr = 1; acc_wdata = a;
      @(negedge cpu_clk); acc_wdata = bval;
      chk(busy === 1'b1, "R6", "busy before second write", 32'(busy), 1);
      @(negedge cpu_clk); acc_wr = 0;
      exp_mem[0] = a; exp_ptr = 1;
      chk(ptr_val === PW'(1), "R6", "pointer after dropped write", 32'(ptr_val), 1);
      wait_idle(n);
      repeat (12) @(negedge cpu_clk);
      chk(flt_mask[31:0] === a, "R6", "receive copy word 0", flt_mask[31:0], a);
      chk(flt_mask[63:32] === exp_mem[1], "R6", "receive copy word 1",
          flt_mask[63:32], exp_mem[1]);
      do_clr();
      do_read();
      do_read();

      // R7: outputs change only after crossing, present when busy falls
      do_clr();
      c = 32'h1234_5678;
      @(negedge cpu_clk); acc_wr = 1; acc_wdata = c;
      @(negedge cpu_clk); acc_wr = 0;
      chk(flt_mask[31:0] === a, "R7", "old mask right after write", flt_mask[31:0], a);
      wait_idle(n);
      chk(flt_mask[31:0] === c, "R7", "new mask when busy falls", flt_mask[31:0], c);
      exp_mem[0] = c; exp_ptr = 1;

      // R4: clear beats a concurrent write and a concurrent read
      do_write(32'h0F0F_0F0F);
      old_rd = acc_rdata;
      @(negedge cpu_clk); ptr_clr = 1; acc_wr = 1; acc_wdata = 32'hFFFF_FFFF;
      @(negedge cpu_clk); ptr_clr = 0; acc_wr = 0;
      exp_ptr = 0;
      chk(ptr_val === '0, "R4", "pointer after clear with write", 32'(ptr_val), 0);
      chk(busy === 1'b0, "R4", "write dropped under clear", 32'(busy), 0);
      @(negedge cpu_clk); ptr_clr = 1; acc_rd = 1;
      @(negedge cpu_clk); ptr_clr = 0; acc_rd = 0;
      chk(acc_rdata === old_rd, "R4", "read dropped under clear", acc_rdata, old_rd);
      chk(ptr_val === '0, "R4", "pointer after clear with read", 32'(ptr_val), 0);

      // second full pass with a different pattern
      for (int k = 0; k < NW; k++) do_write(pat(k, 1));
      chk_fields();
      for (int k = 0; k < NW; k++) do_read();

      done = 1;
      finish_run();
   end
endmodule